// File: doc/BRIEF.md
# Two-Wire Serial Configuration Write Receiver

This block accepts register writes from a slow two-wire link (one serial clock line, one serial data line) and turns every well-formed frame into a single-cycle write on a parallel configuration bus. Both lines are plain inputs. They are oversampled by the system clock, so the serial clock is never used as a clock inside the block.

A frame opens with a start condition. It then carries an 8-bit register address and a 32-bit data word, both most significant bit first. It closes with a stop condition. When the stop closes a frame that carried exactly 40 bits, the block raises its write strobe for one system cycle and presents the address and data. Frames of any other length are dropped without a strobe. A start seen in the middle of a frame abandons that frame and opens a new one. The link has no acknowledge bit, no read path, no device address and no clock stretching.

The transmitter changes the data line only while the serial clock is low. Each serial clock half-period lasts at least four system clock cycles.

Top module: `ser_cfg_bridge`

## Requirements
- R1: Both lines idle high. A start is the data line falling while the serial clock is high. Until a start is seen, serial clock pulses and stop conditions produce no strobe.
- R2: The first 8 bits after a start form the address, first bit received in bit 7. On the strobe, they appear on `wr_addr_o[7:0]`.
- R3: The next 32 bits form the data word, first bit received in bit 31. On the strobe, they appear on `wr_data_o[31:0]`.
- R4: Each bit takes the data line value at the rising edge of the serial clock. Changes on the data line while the serial clock is low have no effect on the received value.
- R5: A stop (data line rising while the serial clock is high) after exactly 40 bits drives `wr_strobe_o` high for exactly one system cycle. Address and data are valid in that cycle and hold until the next strobe.
- R6: A start seen in the middle of a frame discards the bits received so far. The frame that follows is received as a fresh 40-bit frame.
- R7: A stop after fewer than 40 bits, or after more than 40 bits, gives no strobe and leaves `wr_addr_o` and `wr_data_o` unchanged.
- R8: Frames are received correctly when every serial clock half-period lasts 4 system clock cycles.
- R9: While `rst_n` is low and after its release, `wr_strobe_o` is 0, `wr_addr_o` and `wr_data_o` are 0, and the receiver waits for a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| ser_clk_i | input | 1 | Serial clock line, asynchronous to `clk` |
| ser_dat_i | input | 1 | Serial data line, asynchronous to `clk` |
| wr_strobe_o | output | 1 | One-cycle write strobe for a complete frame |
| wr_addr_o | output | 8 | Register address of the last accepted frame |
| wr_data_o | output | 32 | Data word of the last accepted frame |

## Verification
The bench targets frame length at both sides of 40 bits. A receiver that counts the stop condition's own clock rise as a bit, or that does not check the count, would strobe on 39-bit or 41-bit frames or reject good ones. It toggles the data line while the serial clock is low, which catches a receiver that samples at the wrong time. It sends a repeated start in the middle of a frame; a design that keeps counting would strobe with shifted or stale fields. It also sends serial clock pulses and a stop with no start first, and runs at the minimum four-cycle half-period, where extra synchronizer delay or a missed edge would corrupt bits.

// File: rtl/scb_pkg.sv
package scb_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } line_evt_t;

endpackage

// File: rtl/scb_rst_sync.sv
module scb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] rst_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

endmodule

// File: rtl/scb_line_sync.sv
module scb_line_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] hist_o
);

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              hist_q;

    // Lines idle high, so reset to 1 to avoid a false edge after reset.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        hist_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], line_i[g]};
        hist_q  <= chain_q[STAGES-1];
      end
    end

    assign sync_o[g] = chain_q[STAGES-1];
    assign hist_o[g] = hist_q;
  end

endmodule

// File: rtl/scb_cond_detect.sv
module scb_cond_detect
  import scb_pkg::*;
(
  input  logic      sclk_now,
  input  logic      sclk_old,
  input  logic      sdat_now,
  input  logic      sdat_old,
  output line_evt_t evt_o
);

  logic clk_held_high;

  always_comb begin
    clk_held_high = sclk_now & sclk_old;
    evt_o.start   = clk_held_high &  sdat_old & ~sdat_now;
    evt_o.stop    = clk_held_high & ~sdat_old &  sdat_now;
    evt_o.rise    =  sclk_now & ~sclk_old;
    evt_o.fall    = ~sclk_now &  sclk_old;
  end

endmodule

// File: rtl/scb_frame_rx.sv
module scb_frame_rx
  import scb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_evt_t         evt_i,
  input  logic              sdat_i,
  output logic              stb_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned FRAME_W = ADDR_W + DATA_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  rx_state_e          state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               pend_q, pend_d;
  logic               pend_vld_q, pend_vld_d;
  logic               stb_q, stb_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [DATA_W-1:0]  data_q, data_d;
  logic               shift_en;
  logic               out_en;

  // Next-state logic. A bit is sampled at the serial clock rise and
  // committed at the following fall, so the rise that sets up a stop
  // never counts as a bit.
  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    shreg_d    = shreg_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    stb_d      = 1'b0;
    shift_en   = 1'b0;
    out_en     = 1'b0;

    if (evt_i.start) begin
      state_d    = RX_BUSY;
      cnt_d      = '0;
      pend_vld_d = 1'b0;
    end else if (evt_i.stop) begin
      state_d    = RX_IDLE;
      pend_vld_d = 1'b0;
      if (state_q == RX_BUSY && cnt_q == CNT_FULL) begin
        stb_d  = 1'b1;
        out_en = 1'b1;
      end
    end else if (state_q == RX_BUSY) begin
      if (evt_i.rise) begin
        pend_d     = sdat_i;
        pend_vld_d = 1'b1;
      end else if (evt_i.fall && pend_vld_q) begin
        pend_vld_d = 1'b0;
        shift_en   = (cnt_q < CNT_FULL);
        if (cnt_q != CNT_SAT) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end

    if (shift_en) begin
      shreg_d = {shreg_q[FRAME_W-2:0], pend_q};
    end
  end

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (out_en) begin
      addr_d = shreg_q[FRAME_W-1 -: ADDR_W];
      data_d = shreg_q[DATA_W-1:0];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      pend_q     <= 1'b0;
      pend_vld_q <= 1'b0;
      stb_q      <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      shreg_q    <= shreg_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      stb_q      <= stb_d;
      addr_q     <= addr_d;
      data_q     <= data_d;
    end
  end

  assign stb_o  = stb_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R5
  AST_STB_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> state_q == RX_IDLE); // R5
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_SAT); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.start |=> (cnt_q == '0 && state_q == RX_BUSY)); // R6
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_IDLE && !evt_i.start) |=> $stable(cnt_q)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> ($stable(addr_q) && $stable(data_q))); // R7

endmodule

// File: rtl/ser_cfg_bridge.sv
module ser_cfg_bridge #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  import scb_pkg::*;

  localparam int unsigned LINE_W = 2;
  localparam int unsigned IDX_CLK = 1;
  localparam int unsigned IDX_DAT = 0;

  logic              rst_sync_n;
  logic [LINE_W-1:0] line_now;
  logic [LINE_W-1:0] line_old;
  line_evt_t         evt;

  scb_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scb_line_sync #(
    .W      (LINE_W),
    .STAGES (SYNC_STAGES)
  ) u_line_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .line_i ({ser_clk_i, ser_dat_i}),
    .sync_o (line_now),
    .hist_o (line_old)
  );

  scb_cond_detect u_cond (
    .sclk_now (line_now[IDX_CLK]),
    .sclk_old (line_old[IDX_CLK]),
    .sdat_now (line_now[IDX_DAT]),
    .sdat_old (line_old[IDX_DAT]),
    .evt_o    (evt)
  );

  scb_frame_rx #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt_i  (evt),
    .sdat_i (line_now[IDX_DAT]),
    .stb_o  (wr_strobe_o),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o)
  );

endmodule

// File: tb/sim_ser_cfg_bridge.sv
module sim_ser_cfg_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        sclk;
  logic        sdat;
  logic        wr_strobe;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int width_err = 0;
  logic        prev_stb = 1'b0;
  logic [7:0]  cap_addr = '0;
  logic [31:0] cap_data = '0;
  logic        done = 1'b0;

  ser_cfg_bridge u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_clk_i   (sclk),
    .ser_dat_i   (sdat),
    .wr_strobe_o (wr_strobe),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (wr_strobe) begin
      pulses   <= pulses + 1;
      cap_addr <= wr_addr;
      cap_data <= wr_data;
      if (prev_stb) width_err <= width_err + 1;
    end
    prev_stb <= wr_strobe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input int hp);
    sclk = 1'b0; wait_cyc(hp);
    sdat = 1'b1; wait_cyc(hp);
    sclk = 1'b1; wait_cyc(hp);
    sdat = 1'b0; wait_cyc(hp);
  endtask

  task automatic send_bit(input logic b, input int hp, input bit glitch);
    sclk = 1'b0;
    if (glitch) begin
      sdat = ~b; wait_cyc(1);
      sdat = b;  wait_cyc(hp - 1);
    end else begin
      sdat = b;  wait_cyc(hp);
    end
    sclk = 1'b1; wait_cyc(hp);
  endtask

  task automatic send_vec(input logic [63:0] v, input int n, input int hp,
                          input bit glitch);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i], hp, glitch);
  endtask

  task automatic do_stop(input int hp);
    sclk = 1'b0; sdat = 1'b0; wait_cyc(hp);
    sclk = 1'b1; wait_cyc(hp);
    sdat = 1'b1; wait_cyc(hp);
    wait_cyc(8);
  endtask

  task automatic frame_ok(input logic [7:0] a, input logic [31:0] d,
                          input int hp, input bit glitch, input string req);
    int p0 = pulses;
    do_start(hp);
    send_vec({24'h0, a, d}, 40, hp, glitch);
    do_stop(hp);
    chk(pulses == p0 + 1, {req, " strobe count"}, 64'(pulses - p0), 64'd1);
    chk(cap_addr == a, {req, " address"}, 64'(cap_addr), 64'(a));
    chk(cap_data == d, {req, " data"}, 64'(cap_data), 64'(d));
  endtask

  task automatic t_reset;
    chk(wr_strobe == 1'b0, "R9 strobe at reset", 64'(wr_strobe), 64'd0);
    chk(wr_addr == '0, "R9 address at reset", 64'(wr_addr), 64'd0);
    chk(wr_data == '0, "R9 data at reset", 64'(wr_data), 64'd0);
  endtask

  task automatic t_basic_min_rate;
    frame_ok(8'hA5, 32'hDEADBEEF, 4, 1'b0, "R2 R3 R5 R8 basic");
  endtask

  task automatic t_glitch_low;
    frame_ok(8'h3C, 32'h12345678, 6, 1'b1, "R4 glitch while clock low");
    frame_ok(8'h81, 32'h80000001, 5, 1'b1, "R2 R3 edge bits");
  endtask

  task automatic t_short_frame;
    int p0 = pulses;
    do_start(4);
    send_vec(64'h55_AAAAAAAA, 39, 4, 1'b0);
    do_stop(4);
    chk(pulses == p0, "R7 short frame strobe", 64'(pulses - p0), 64'd0);
    chk(wr_addr == 8'h81, "R7 short frame addr kept", 64'(wr_addr), 64'h81);
  endtask

  task automatic t_long_frame;
    int p0 = pulses;
    do_start(4);
    send_vec(64'h1_FF_0F0F0F0F, 41, 4, 1'b0);
    do_stop(4);
    chk(pulses == p0, "R7 long frame strobe", 64'(pulses - p0), 64'd0);
    chk(wr_data == 32'h80000001, "R7 long frame data kept", 64'(wr_data),
        64'h80000001);
  endtask

  task automatic t_restart;
    int p0 = pulses;
    do_start(4);
    send_vec(64'hFFFFF, 20, 4, 1'b0);
    frame_ok(8'h42, 32'hCAFEF00D, 4, 1'b0, "R6 restart");
    chk(pulses == p0 + 1, "R6 restart total strobes", 64'(pulses - p0), 64'd1);
  endtask

  task automatic t_no_start;
    int p0 = pulses;
    send_vec({24'h0, 8'h77, 32'h11223344}, 40, 4, 1'b0);
    do_stop(4);
    chk(pulses == p0, "R1 no start strobe", 64'(pulses - p0), 64'd0);
    chk(wr_addr == 8'h42, "R1 no start addr kept", 64'(wr_addr), 64'h42);
  endtask

  task automatic t_width;
    chk(width_err == 0, "R5 strobe width", 64'(width_err), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    sclk  = 1'b1;
    sdat  = 1'b1;
    wait_cyc(4);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(6);
    t_reset();
    t_basic_min_rate();
    t_glitch_low();
    t_short_frame();
    t_long_frame();
    t_restart();
    t_no_start();
    t_width();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule